// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block owns an 8-bit power control register. It also runs the sequence that takes the device into a low-power mode and brings it back out. Software programs the register through a simple write port. A supervisor qualifier guards that port, and the current contents can always be read back. When the core reports that it has executed a stop instruction and the register's arm bit is set, the controller latches the selected mode. One cycle later it drops the clock enables that belong to that mode.

While the device sleeps, a small comparator watches the incoming unmasked interrupt level. The comparator uses no gated clock. Once the level is strictly above the programmed threshold, the block raises an exit request. On the next cycle it turns every clock enable back on, and one cycle after that it returns to run so the core can service the interrupt. The block drives clock enables only. The gating cells, the interrupt arbitration and the processor sit outside it.

Top module: `lpwr_ctrl`

## Requirements
- R1: After reset the register reads 0x00, all three clock enables are 1, the current mode output is 00 and the exit request is 0.
- R2: A write with the supervisor qualifier high, made while the controller is in run, stores the written byte. The stored fields are: bit 7 arm, bits 5:4 mode select, bits 3:0 wake threshold. Bit 6 always reads back as 0.
- R3: A write with the supervisor qualifier low leaves the register unchanged.
- R4: A stop indication while the arm bit is 0 changes nothing: the clock enables stay 1 and the mode output stays 00.
- R5: A stop indication while the arm bit is 1 loads the mode select into the mode output on the following clock edge, and the clock enables stay 1 for that cycle. From the next edge on, the enables follow the mode. Mode 00 gates nothing. Mode 01 clears the core enable. Mode 10 clears the core and bus enables. Mode 11 clears the core, bus and peripheral enables.
- R6: The exit request is raised only while in low power, and only when the 3-bit interrupt level, zero-extended to 4 bits, is strictly greater than the threshold. A level of 0, or a level equal to the threshold, raises nothing.
- R7: In low power, the exit request follows a change of interrupt level within the same cycle, with no clock edge needed.
- R8: On the clock edge after the exit request, all clock enables return to 1 while the mode output still shows the sleeping mode. One edge later the mode output returns to 00.
- R9: Register writes made while the controller is in any state other than run are ignored, even with the supervisor qualifier high.
- R10: With a threshold of 7 or more, no interrupt level can raise an exit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock of the wake logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sup | input | 1 | Write comes from supervisor mode |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Current register contents |
| stop_exec | input | 1 | Core has executed a stop instruction |
| irq_level | input | 3 | Highest unmasked pending interrupt level, 0 = none |
| core_clk_en | output | 1 | Enable for the core clock domain |
| bus_clk_en | output | 1 | Enable for the bus clock domain |
| per_clk_en | output | 1 | Enable for the peripheral clock domain |
| lp_mode | output | 2 | Mode currently in force, 00 while running |
| exit_req | output | 1 | Request to leave low power |

## Verification
The hardest situation to reach is a sleep that nothing can end. Once armed with a threshold of 7 or more, the controller rejects both register writes and every interrupt level, so only reset can free it. The stimulus reaches this on purpose: it programs a threshold of 7, drives the top interrupt level while in doze, and then recovers with a mid-run reset. The same-cycle response of the exit request is checked between clock edges, right after the level changes.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;
    localparam int CFG_W   = 8;
    localparam int ARM_BIT = 7;
    localparam int RSV_BIT = 6;
    localparam int MD_HI   = 5;
    localparam int MD_LO   = 4;
    localparam int MD_W    = MD_HI - MD_LO + 1;
    localparam int THR_W   = 4;
    localparam int LVL_W   = 3;
    localparam int NUM_DOM = 3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_LOWPWR = 2'd2,
        ST_EXIT   = 2'd3
    } lp_state_e;

    typedef enum logic [MD_W-1:0] {
        MD_RUN  = 2'd0,
        MD_DOZE = 2'd1,
        MD_WAIT = 2'd2,
        MD_STOP = 2'd3
    } lp_mode_e;

    typedef struct packed {
        logic             arm;
        logic [MD_W-1:0]  msel;
        logic [THR_W-1:0] thr;
    } cfg_t;
endpackage

// File: rtl/lpwr_cfg_reg.sv
module lpwr_cfg_reg
    import lpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sup,
    input  logic             wr_allow,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rd_data
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_sup && wr_allow) begin
            cfg_d.arm  = wr_data[ARM_BIT];
            cfg_d.msel = wr_data[MD_HI:MD_LO];
            cfg_d.thr  = wr_data[THR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data                = '0;
        rd_data[ARM_BIT]       = cfg_q.arm;
        rd_data[RSV_BIT]       = 1'b0;
        rd_data[MD_HI:MD_LO]   = cfg_q.msel;
        rd_data[THR_W-1:0]     = cfg_q.thr;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/lpwr_wake_cmp.sv
module lpwr_wake_cmp #(
    parameter int LVL_W = 3,
    parameter int THR_W = 4
) (
    input  logic             armed,
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thresh,
    output logic             wake
);
    localparam int PAD = THR_W - LVL_W;
    logic [THR_W-1:0] level_ext;

    generate
        if (PAD > 0) begin : g_pad
            assign level_ext = {{PAD{1'b0}}, level};
        end else begin : g_nopad
            assign level_ext = level[THR_W-1:0];
        end
    endgenerate

    assign wake = armed && (level_ext > thresh);
endmodule

// File: rtl/lpwr_fsm.sv
module lpwr_fsm
    import lpwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_exec,
    input  logic            arm,
    input  logic [MD_W-1:0] msel,
    input  logic            wake,
    output lp_state_e       state,
    output logic [MD_W-1:0] act_mode
);
    typedef struct packed {
        lp_state_e st;
        lp_mode_e  md;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (stop_exec && arm) begin
                    r_d.st = ST_ENTER;
                    r_d.md = lp_mode_e'(msel);
                end
            end
            ST_ENTER:  r_d.st = ST_LOWPWR;
            ST_LOWPWR: if (wake) r_d.st = ST_EXIT;
            ST_EXIT: begin
                r_d.st = ST_RUN;
                r_d.md = MD_RUN;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_RUN;
            r_q.md <= MD_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign act_mode = r_q.md;
endmodule

// File: rtl/lpwr_clk_dec.sv
module lpwr_clk_dec #(
    parameter int NUM_DOM = 3,
    parameter int MD_W    = 2
) (
    input  logic               gate,
    input  logic [MD_W-1:0]    mode,
    output logic [NUM_DOM-1:0] clk_en
);
    generate
        for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
            assign clk_en[g] = !(gate && (int'(mode) > g));
        end
    endgenerate
endmodule

// File: rtl/lpwr_ctrl.sv
module lpwr_ctrl
    import lpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sup,
    input  logic [CFG_W-1:0] reg_wr_data,
    output logic [CFG_W-1:0] reg_rd_data,
    input  logic             stop_exec,
    input  logic [LVL_W-1:0] irq_level,
    output logic             core_clk_en,
    output logic             bus_clk_en,
    output logic             per_clk_en,
    output logic [MD_W-1:0]  lp_mode,
    output logic             exit_req
);
    cfg_t               cfg;
    lp_state_e          state_q;
    logic [MD_W-1:0]    act_mode;
    logic               in_lp;
    logic               wake;
    logic [NUM_DOM-1:0] dom_en;

    assign in_lp = (state_q == ST_LOWPWR);

    lpwr_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_sup   (reg_wr_sup),
        .wr_allow (state_q == ST_RUN),
        .wr_data  (reg_wr_data),
        .cfg      (cfg),
        .rd_data  (reg_rd_data)
    );

    lpwr_wake_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
        .armed  (in_lp),
        .level  (irq_level),
        .thresh (cfg.thr),
        .wake   (wake)
    );

    lpwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_exec (stop_exec),
        .arm       (cfg.arm),
        .msel      (cfg.msel),
        .wake      (wake),
        .state     (state_q),
        .act_mode  (act_mode)
    );

    lpwr_clk_dec #(.NUM_DOM(NUM_DOM), .MD_W(MD_W)) u_dec (
        .gate   (in_lp),
        .mode   (act_mode),
        .clk_en (dom_en)
    );

    assign core_clk_en = dom_en[0];
    assign bus_clk_en  = dom_en[1];
    assign per_clk_en  = dom_en[2];
    assign lp_mode     = act_mode;
    assign exit_req    = wake;
endmodule

// File: rtl/lpwr_ctrl_chk.sv
module lpwr_ctrl_chk
    import lpwr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_wr_sup,
    input logic [CFG_W-1:0] reg_rd_data,
    input logic             stop_exec,
    input logic [LVL_W-1:0] irq_level,
    input logic             core_clk_en,
    input logic             bus_clk_en,
    input logic             per_clk_en,
    input logic             exit_req,
    input lp_state_e        state_q
);
    AST_USER_WR_NOCHG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sup) |=> $stable(reg_rd_data)); // R3
    AST_LOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && state_q != ST_RUN) |=> $stable(reg_rd_data)); // R9
    AST_STOP_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_exec && !reg_rd_data[ARM_BIT]) |=> (state_q == ST_RUN && core_clk_en)); // R4
    AST_GATE_ONLY_LP: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en || !bus_clk_en || !per_clk_en) |-> (state_q == ST_LOWPWR)); // R5
    AST_EXIT_ONLY_LP: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> (state_q == ST_LOWPWR)); // R6
    AST_EXIT_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> ({1'b0, irq_level} > reg_rd_data[THR_W-1:0])); // R6
    AST_EXIT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (core_clk_en && bus_clk_en && per_clk_en)); // R8
endmodule

bind lpwr_ctrl lpwr_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sup  (reg_wr_sup),
    .reg_rd_data (reg_rd_data),
    .stop_exec   (stop_exec),
    .irq_level   (irq_level),
    .core_clk_en (core_clk_en),
    .bus_clk_en  (bus_clk_en),
    .per_clk_en  (per_clk_en),
    .exit_req    (exit_req),
    .state_q     (state_q)
);

// File: tb/sim_lpwr_ctrl.sv
`timescale 1ns/1ps
module sim_lpwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_wr_sup = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       stop_exec = 1'b0;
    logic [2:0] irq_level = '0;
    logic       core_clk_en, bus_clk_en, per_clk_en;
    logic [1:0] lp_mode;
    logic       exit_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic [7:0] rd;
        logic [2:0] en;
        logic [1:0] md;
        logic       ex;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    lpwr_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sup(reg_wr_sup),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .stop_exec(stop_exec), .irq_level(irq_level),
        .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
        .per_clk_en(per_clk_en), .lp_mode(lp_mode), .exit_req(exit_req)
    );

    // Expected enable vector {per,bus,core} for a gated mode
    function automatic logic [2:0] gated(input logic [1:0] m);
        return {m < 2'd3, m < 2'd2, m < 2'd1};
    endfunction

    // Monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (reg_rd_data !== e.rd || {per_clk_en, bus_clk_en, core_clk_en} !== e.en ||
                    lp_mode !== e.md || exit_req !== e.ex) begin
                    fails++;
                    $display("FAIL %s: rd=%h en=%b md=%0d ex=%b expected rd=%h en=%b md=%0d ex=%b",
                             e.req, reg_rd_data, {per_clk_en, bus_clk_en, core_clk_en}, lp_mode,
                             exit_req, e.rd, e.en, e.md, e.ex);
                end
            end
        end
    end

    // Driver: sets inputs at the falling edge, queues the state after the next rising edge
    task automatic step(input string req, input bit wr, input bit sup, input logic [7:0] d,
                        input bit stp, input logic [2:0] lvl,
                        input logic [7:0] erd, input logic [2:0] een,
                        input logic [1:0] emd, input logic eex);
        exp_t e;
        @(negedge clk);
        reg_wr_en = wr; reg_wr_sup = sup; reg_wr_data = d;
        stop_exec = stp; irq_level = lvl;
        e.req = req; e.rd = erd; e.en = een; e.md = emd; e.ex = eex;
        sb.push_back(e);
        @(posedge clk);
    endtask

    task automatic comb_check(input string req, input logic [2:0] lvl, input logic eex);
        @(negedge clk);
        reg_wr_en = 0; stop_exec = 0; irq_level = lvl;
        #1;
        checks++;
        if (exit_req !== eex) begin
            fails++;
            $display("FAIL %s: exit_req=%b expected %b", req, exit_req, eex);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; reg_wr_en = 0; stop_exec = 0; irq_level = 0;
        #3;
        rst_n = 1;
    endtask

    initial begin
        #23 rst_n = 1'b1;
        // R1 reset state
        step("R1", 0,0,8'h00, 0,3'd0, 8'h00, 3'b111, 2'd0, 0);
        // R3 user write ignored
        step("R3", 1,0,8'hBF, 0,3'd0, 8'h00, 3'b111, 2'd0, 0);
        // R2 supervisor write, reserved bit reads 0
        step("R2", 1,1,8'hFF, 0,3'd0, 8'hBF, 3'b111, 2'd0, 0);
        step("R2", 1,1,8'h25, 0,3'd0, 8'h25, 3'b111, 2'd0, 0);
        // R4 stop with arm clear
        step("R4", 0,0,8'h00, 1,3'd0, 8'h25, 3'b111, 2'd0, 0);
        step("R4", 0,0,8'h00, 0,3'd0, 8'h25, 3'b111, 2'd0, 0);
        // Wait mode, threshold 3
        step("R2", 1,1,8'hA3, 0,3'd0, 8'hA3, 3'b111, 2'd0, 0);
        step("R5", 0,0,8'h00, 1,3'd0, 8'hA3, 3'b111, 2'd2, 0);
        step("R5", 0,0,8'h00, 0,3'd0, 8'hA3, gated(2'd2), 2'd2, 0);
        // R9 write during low power ignored
        step("R9", 1,1,8'h00, 0,3'd0, 8'hA3, gated(2'd2), 2'd2, 0);
        // R6 equal level does not wake
        step("R6", 0,0,8'h00, 0,3'd3, 8'hA3, gated(2'd2), 2'd2, 0);
        // R7 level above threshold wakes within the cycle
        comb_check("R7", 3'd4, 1'b1);
        @(posedge clk);
        #2;
        checks++;
        if ({per_clk_en, bus_clk_en, core_clk_en} !== 3'b111 || lp_mode !== 2'd2) begin
            fails++;
            $display("FAIL R8: en=%b md=%0d expected en=111 md=2",
                     {per_clk_en, bus_clk_en, core_clk_en}, lp_mode);
        end
        step("R8", 0,0,8'h00, 0,3'd0, 8'hA3, 3'b111, 2'd0, 0);
        // Stop mode, threshold 0
        step("R2", 1,1,8'hB0, 0,3'd0, 8'hB0, 3'b111, 2'd0, 0);
        step("R5", 0,0,8'h00, 1,3'd0, 8'hB0, 3'b111, 2'd3, 0);
        step("R5", 0,0,8'h00, 0,3'd0, 8'hB0, gated(2'd3), 2'd3, 0);
        step("R6", 0,0,8'h00, 0,3'd0, 8'hB0, gated(2'd3), 2'd3, 0);
        comb_check("R7", 3'd1, 1'b1);
        @(posedge clk);
        step("R8", 0,0,8'h00, 0,3'd0, 8'hB0, 3'b111, 2'd0, 0);
        // Doze with threshold 7: top level cannot wake
        step("R2", 1,1,8'h97, 0,3'd0, 8'h97, 3'b111, 2'd0, 0);
        step("R5", 0,0,8'h00, 1,3'd0, 8'h97, 3'b111, 2'd1, 0);
        step("R5", 0,0,8'h00, 0,3'd0, 8'h97, gated(2'd1), 2'd1, 0);
        comb_check("R10", 3'd7, 1'b0);
        step("R10", 0,0,8'h00, 0,3'd7, 8'h97, gated(2'd1), 2'd1, 0);
        step("R10", 0,0,8'h00, 0,3'd7, 8'h97, gated(2'd1), 2'd1, 0);
        do_reset();
        step("R1", 0,0,8'h00, 0,3'd0, 8'h00, 3'b111, 2'd0, 0);
        // Armed with mode 00: no gating, still wakes
        step("R2", 1,1,8'h80, 0,3'd0, 8'h80, 3'b111, 2'd0, 0);
        step("R5", 0,0,8'h00, 1,3'd0, 8'h80, 3'b111, 2'd0, 0);
        step("R5", 0,0,8'h00, 0,3'd0, 8'h80, 3'b111, 2'd0, 0);
        comb_check("R6", 3'd1, 1'b1);
        @(posedge clk);
        step("R8", 0,0,8'h00, 0,3'd0, 8'h80, 3'b111, 2'd0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule